// File: doc/BRIEF.md
# Interrupt Controller Command Word Interface

This block is the byte-wide register front end of an eight-line interrupt controller. Software reaches it through two addresses. Writes to address 0 are decoded as command words. Writes to address 1 are routed either into a multi-step initialization sequence or into the mask register, depending on where that sequence stands. The block holds the programmable settings: the mask, the vector base, auto end-of-interrupt, special fully nested mode, rotate-on-auto-EOI, special mask and read-select. It drives these settings, together with one-cycle command pulses, into a separate priority resolver.

The resolver is not part of this block. It supplies its request and in-service registers and its current poll winner, so that reads can return them. Reads are registered, and their data appears one cycle after the read strobe. After a poll command, the next read becomes an acknowledge. That read returns the winning line and tells the resolver to retire it.

Top module: `icw_port`

## Requirements
- R1: After reset, the mask, vector base, auto-EOI, nested mode, rotate-on-auto-EOI, special mask and read-select are all 0. No command, init, read or acknowledge pulse is active.
- R2: A write to address 0 with bit 4 set starts initialization, even while a sequence is already in progress. It has the following effects:
  - It clears the mask, special mask and read-select.
  - It pulses `initClr` for one cycle, so that the resolver clears its stored line levels and its rotation base.
  - It records bit 0 as the request for a fourth word.
  - When bit 0 is 0, it also clears auto-EOI and nested mode.
- R3: The first address-1 write after an initialization start loads the vector base from bits 7:3 and leaves the mask unchanged.
- R4: The second address-1 write after an initialization start is discarded and changes no setting. If no fourth word was requested, the sequence is complete, and the next address-1 write loads the mask.
- R5: When a fourth word was requested, the third address-1 write of the sequence sets nested mode from bit 4 and auto-EOI from bit 1. The sequence is then complete.
- R6: Outside the initialization sequence, an address-1 write loads the full 8-bit mask.
- R7: An address-0 write with bit 4 = 0 and bit 3 = 1 is a read/poll control word:
  - Bit 2 = 1 arms poll.
  - Bit 1 = 1 loads read-select from bit 0.
  - Bit 6 = 1 loads special mask from bit 5.
  - A cleared enable bit leaves its setting unchanged.
- R8: An address-0 write with bits 4 and 3 both 0 is a command word with code = bits 7:5. Codes 0 and 4 load rotate-on-auto-EOI from bit 7.
- R9: Each command code raises its pulses in the cycle after the write, for exactly one cycle:

  | Code | Meaning | Pulses |
  |---|---|---|
  | 1 | non-specific EOI | `eoiReq` |
  | 5 | rotating non-specific EOI | `eoiReq` and `eoiRot` |
  | 3 | specific EOI | `eoiReq` and `eoiSpec` |
  | 7 | rotating specific EOI | `eoiReq`, `eoiSpec` and `eoiRot` |
  | 6 | set priority | `setPrio` |
  | 2 | none | no pulse |

  For codes 3, 6 and 7, `cmdLine` carries bits 2:0.
- R10: When poll is not armed, `rdData` and `rdValid` appear in the cycle after `rdEn`. A read of address 0 returns `isrIn` if read-select is 1 and `irrIn` otherwise. A read of address 1 returns the mask.
- R11: When poll is armed, the next read disarms it, whatever its address.
  - If `pollHit` is 1, the read returns `pollLine` zero-extended and pulses `pollAck` together with `rdValid`.
  - If `pollHit` is 0, it returns 7 and does not pulse `pollAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 1 | Register address |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| wrData | input | 8 | Write byte |
| irrIn | input | 8 | Request register from the resolver |
| isrIn | input | 8 | In-service register from the resolver |
| pollHit | input | 1 | Resolver has a line to grant |
| pollLine | input | 3 | Line the resolver would grant |
| rdData | output | 8 | Registered read data |
| rdValid | output | 1 | Read data valid pulse |
| pollAck | output | 1 | Poll read retired `pollLine` |
| maskReg | output | 8 | Line mask |
| vecBase | output | 5 | Vector base (upper five bits) |
| autoEoi | output | 1 | Auto end-of-interrupt enabled |
| nestedMode | output | 1 | Special fully nested mode |
| rotAutoEoi | output | 1 | Rotate on auto end-of-interrupt |
| specialMask | output | 1 | Special mask mode |
| initClr | output | 1 | Initialization clear pulse for the resolver |
| eoiReq | output | 1 | End-of-interrupt pulse |
| eoiSpec | output | 1 | EOI targets `cmdLine` |
| eoiRot | output | 1 | EOI also rotates priority |
| setPrio | output | 1 | Set-priority pulse |
| cmdLine | output | 3 | Line for specific commands |

## Verification
If the sequence state is lost, address-1 writes go to the wrong place. A mask write lands in the vector base, or an intended mode word overwrites the mask. This shows on `maskReg` or `vecBase` one cycle after the misrouted write. A wrong read-select or a stuck poll flag shows on the very next read, which returns the wrong register, a poll result or a spurious `pollAck`. Command decode errors show one cycle after the write, as a wrong pulse combination or as a pulse that lasts longer than one cycle.

// File: rtl/icw_pkg.sv
package icw_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_BASE,
    SEQ_SKIP,
    SEQ_MODE
  } seqState_e;

  typedef struct packed {
    logic initGo;
    logic initNeed4;
    logic loadBase;
    logic loadMode;
    logic loadMask;
    logic setRsel;
    logic setSmm;
    logic setRotAeoi;
    logic cmdEoi;
    logic cmdSpec;
    logic cmdRot;
    logic cmdPrio;
    logic readNormal;
    logic readPoll;
  } ctrlStb_t;
endpackage

// File: rtl/icw_ctrl.sv
module icw_ctrl
  import icw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          addr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wrData,
  output ctrlStb_t      stb
);
  seqState_e seqState;
  logic      need4;
  logic      pollArmed;
  logic      wrA0, wrA1, isInit, isRdCtl, isCmd;
  logic [2:0] cmdCode;

  assign wrA0    = wrEn && !addr;
  assign wrA1    = wrEn && addr;
  assign isInit  = wrA0 && wrData[4];
  assign isRdCtl = wrA0 && !wrData[4] && wrData[3];
  assign isCmd   = wrA0 && !wrData[4] && !wrData[3];
  assign cmdCode = wrData[7:5];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SEQ_IDLE;
      need4    <= 1'b0;
    end else if (isInit) begin
      seqState <= SEQ_BASE;
      need4    <= wrData[0];
    end else if (wrA1) begin
      case (seqState)
        SEQ_BASE: seqState <= SEQ_SKIP;
        SEQ_SKIP: seqState <= need4 ? SEQ_MODE : SEQ_IDLE;
        SEQ_MODE: seqState <= SEQ_IDLE;
        default:  seqState <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pollArmed <= 1'b0;
    else if (isRdCtl && wrData[2]) pollArmed <= 1'b1;
    else if (rdEn) pollArmed <= 1'b0;
  end

  always_comb begin
    stb            = '0;
    stb.initGo     = isInit;
    stb.initNeed4  = wrData[0];
    stb.loadBase   = wrA1 && (seqState == SEQ_BASE);
    stb.loadMode   = wrA1 && (seqState == SEQ_MODE);
    stb.loadMask   = wrA1 && (seqState == SEQ_IDLE);
    stb.setRsel    = isRdCtl && wrData[1];
    stb.setSmm     = isRdCtl && wrData[6];
    stb.readPoll   = rdEn && pollArmed;
    stb.readNormal = rdEn && !pollArmed;
    if (isCmd) begin
      case (cmdCode)
        3'd0, 3'd4: stb.setRotAeoi = 1'b1;
        3'd1: stb.cmdEoi = 1'b1;
        3'd5: begin stb.cmdEoi = 1'b1; stb.cmdRot = 1'b1; end
        3'd3: begin stb.cmdEoi = 1'b1; stb.cmdSpec = 1'b1; end
        3'd7: begin stb.cmdEoi = 1'b1; stb.cmdSpec = 1'b1; stb.cmdRot = 1'b1; end
        3'd6: stb.cmdPrio = 1'b1;
        default: ;
      endcase
    end
  end

  // R2: an init start always restarts the sequence
  p_init_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    isInit |=> seqState == SEQ_BASE);

  // R11: a poll read leaves poll disarmed unless rearmed in the same cycle
  p_poll_once_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readPoll && !(isRdCtl && wrData[2])) |=> !pollArmed);

  // R4: the discarded word only ever follows the base word
  p_skip_after_base_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_SKIP) |-> ($past(seqState) == SEQ_BASE || $past(seqState) == SEQ_SKIP));
endmodule

// File: rtl/icw_dp.sv
module icw_dp
  import icw_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addr,
  input  ctrlStb_t         stb,
  input  logic [DW-1:0]    wrData,
  input  logic [DW-1:0]    irrIn,
  input  logic [DW-1:0]    isrIn,
  input  logic             pollHit,
  input  logic [LW-1:0]    pollLine,
  output logic [DW-1:0]    rdData,
  output logic             rdValid,
  output logic             pollAck,
  output logic [DW-1:0]    maskReg,
  output logic [DW-LW-1:0] vecBase,
  output logic             autoEoi,
  output logic             nestedMode,
  output logic             rotAutoEoi,
  output logic             specialMask,
  output logic             initClr,
  output logic             eoiReq,
  output logic             eoiSpec,
  output logic             eoiRot,
  output logic             setPrio,
  output logic [LW-1:0]    cmdLine
);
  localparam logic [DW-1:0] NONE_CODE = DW'(7);
  logic readSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg     <= '0;
      vecBase     <= '0;
      autoEoi     <= 1'b0;
      nestedMode  <= 1'b0;
      rotAutoEoi  <= 1'b0;
      specialMask <= 1'b0;
      readSel     <= 1'b0;
    end else begin
      if (stb.initGo) begin
        maskReg     <= '0;
        specialMask <= 1'b0;
        readSel     <= 1'b0;
        if (!stb.initNeed4) begin
          autoEoi    <= 1'b0;
          nestedMode <= 1'b0;
        end
      end
      if (stb.loadMask) maskReg <= wrData;
      if (stb.loadBase) vecBase <= wrData[DW-1:LW];
      if (stb.loadMode) begin
        nestedMode <= wrData[4];
        autoEoi    <= wrData[1];
      end
      if (stb.setRsel) readSel <= wrData[0];
      if (stb.setSmm) specialMask <= wrData[5];
      if (stb.setRotAeoi) rotAutoEoi <= wrData[7];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initClr <= 1'b0;
      eoiReq  <= 1'b0;
      eoiSpec <= 1'b0;
      eoiRot  <= 1'b0;
      setPrio <= 1'b0;
      cmdLine <= '0;
    end else begin
      initClr <= stb.initGo;
      eoiReq  <= stb.cmdEoi;
      eoiSpec <= stb.cmdSpec;
      eoiRot  <= stb.cmdRot;
      setPrio <= stb.cmdPrio;
      if (stb.cmdSpec || stb.cmdPrio) cmdLine <= wrData[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      pollAck <= 1'b0;
    end else begin
      rdValid <= stb.readNormal || stb.readPoll;
      pollAck <= stb.readPoll && pollHit;
      if (stb.readPoll)
        rdData <= pollHit ? DW'(pollLine) : NONE_CODE;
      else if (stb.readNormal)
        rdData <= addr ? maskReg : (readSel ? isrIn : irrIn);
    end
  end

  // R9: a specific EOI is always an EOI; set-priority never overlaps an EOI
  p_spec_is_eoi_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eoiSpec || eoiRot) |-> eoiReq);
  p_prio_alone_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(setPrio && eoiReq));

  // R11: an acknowledge comes only with read data that names a line
  p_ack_with_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    pollAck |-> (rdValid && rdData < DW'(8)));

  // R2: the init clear pulse follows a cleared mask and read settings
  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    initClr |-> (maskReg == '0 && !specialMask && !readSel));

  // R6: the mask moves only on a mask load or an init start
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadMask && !stb.initGo) |=> $stable(maskReg));

  // R3: the vector base moves only on its own load
  p_base_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadBase |=> $stable(vecBase));
endmodule

// File: rtl/icw_port.sv
module icw_port
  import icw_pkg::*;
#(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES),
  localparam int DW = LINES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addr,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [DW-1:0]    wrData,
  input  logic [DW-1:0]    irrIn,
  input  logic [DW-1:0]    isrIn,
  input  logic             pollHit,
  input  logic [LW-1:0]    pollLine,
  output logic [DW-1:0]    rdData,
  output logic             rdValid,
  output logic             pollAck,
  output logic [DW-1:0]    maskReg,
  output logic [DW-LW-1:0] vecBase,
  output logic             autoEoi,
  output logic             nestedMode,
  output logic             rotAutoEoi,
  output logic             specialMask,
  output logic             initClr,
  output logic             eoiReq,
  output logic             eoiSpec,
  output logic             eoiRot,
  output logic             setPrio,
  output logic [LW-1:0]    cmdLine
);
  ctrlStb_t stb;

  icw_ctrl #(.DW(DW)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .stb(stb)
  );

  icw_dp #(.DW(DW), .LW(LW)) i_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .stb(stb), .wrData(wrData),
    .irrIn(irrIn), .isrIn(isrIn), .pollHit(pollHit), .pollLine(pollLine),
    .rdData(rdData), .rdValid(rdValid), .pollAck(pollAck),
    .maskReg(maskReg), .vecBase(vecBase), .autoEoi(autoEoi),
    .nestedMode(nestedMode), .rotAutoEoi(rotAutoEoi),
    .specialMask(specialMask), .initClr(initClr), .eoiReq(eoiReq),
    .eoiSpec(eoiSpec), .eoiRot(eoiRot), .setPrio(setPrio), .cmdLine(cmdLine)
  );
endmodule

// File: tb/test_icw_port.sv
module test_icw_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addr = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0, irrIn = '0, isrIn = '0;
  logic       pollHit = 1'b0;
  logic [2:0] pollLine = '0;
  logic [7:0] rdData, maskReg;
  logic [4:0] vecBase;
  logic [2:0] cmdLine;
  logic rdValid, pollAck, autoEoi, nestedMode, rotAutoEoi, specialMask;
  logic initClr, eoiReq, eoiSpec, eoiRot, setPrio;

  int checks = 0;
  int fails  = 0;

  // bench model of the programmable state
  logic [7:0] mMask = '0;
  logic [4:0] mBase = '0;
  logic mAeoi = 0, mNest = 0, mRot = 0, mSmm = 0, mRsel = 0, mPoll = 0, mNeed4 = 0;
  int   mSeq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icw_port i_icw_port (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .irrIn(irrIn), .isrIn(isrIn), .pollHit(pollHit),
    .pollLine(pollLine), .rdData(rdData), .rdValid(rdValid), .pollAck(pollAck),
    .maskReg(maskReg), .vecBase(vecBase), .autoEoi(autoEoi),
    .nestedMode(nestedMode), .rotAutoEoi(rotAutoEoi), .specialMask(specialMask),
    .initClr(initClr), .eoiReq(eoiReq), .eoiSpec(eoiSpec), .eoiRot(eoiRot),
    .setPrio(setPrio), .cmdLine(cmdLine)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkState(input string tag);
    chk({tag, " mask"}, 32'(maskReg), 32'(mMask));
    chk({tag, " base"}, 32'(vecBase), 32'(mBase));
    chk({tag, " modes"}, {28'd0, autoEoi, nestedMode, rotAutoEoi, specialMask},
        {28'd0, mAeoi, mNest, mRot, mSmm});
  endtask

  task automatic doWrite(input logic a, input logic [7:0] d);
    logic eI, eE, eS, eR, eP;
    string tag;
    eI = 0; eE = 0; eS = 0; eR = 0; eP = 0;
    tag = "R6";
    if (!a) begin
      if (d[4]) begin
        tag = "R2";
        mNeed4 = d[0]; mMask = '0; mSmm = 0; mRsel = 0;
        if (!d[0]) begin mAeoi = 0; mNest = 0; end
        mSeq = 1; eI = 1;
      end else if (d[3]) begin
        tag = "R7";
        if (d[2]) mPoll = 1;
        if (d[1]) mRsel = d[0];
        if (d[6]) mSmm = d[5];
      end else begin
        tag = (d[7:5] == 3'd0 || d[7:5] == 3'd4) ? "R8" : "R9";
        case (d[7:5])
          3'd0, 3'd4: mRot = d[7];
          3'd1: eE = 1;
          3'd5: begin eE = 1; eR = 1; end
          3'd3: begin eE = 1; eS = 1; end
          3'd7: begin eE = 1; eS = 1; eR = 1; end
          3'd6: eP = 1;
          default: ;
        endcase
      end
    end else begin
      case (mSeq)
        0: mMask = d;
        1: begin tag = "R3"; mBase = d[7:3]; mSeq = 2; end
        2: begin tag = "R4"; mSeq = mNeed4 ? 3 : 0; end
        default: begin tag = "R5"; mNest = d[4]; mAeoi = d[1]; mSeq = 0; end
      endcase
    end
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    chkState(tag);
    chk({tag, " pulses"}, {27'd0, eI, eE, eS, eR, eP},
        {27'd0, initClr, eoiReq, eoiSpec, eoiRot, setPrio});
    if (eS || eP) chk({tag, " line"}, 32'(cmdLine), 32'(d[2:0]));
    @(negedge clk);
    chk({tag, " one-cycle pulses"}, {27'd0, initClr, eoiReq, eoiSpec, eoiRot, setPrio}, 32'd0);
  endtask

  task automatic doRead(input logic a, input logic [7:0] irr, input logic [7:0] isr,
                        input logic hit, input logic [2:0] line);
    logic [7:0] eD;
    logic eA;
    string tag;
    if (mPoll) begin
      tag = "R11"; mPoll = 0;
      eD = hit ? {5'd0, line} : 8'd7; eA = hit;
    end else begin
      tag = "R10"; eA = 0;
      eD = a ? mMask : (mRsel ? isr : irr);
    end
    @(negedge clk);
    addr = a; irrIn = irr; isrIn = isr; pollHit = hit; pollLine = line; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    chk({tag, " data"}, 32'(rdData), 32'(eD));
    chk({tag, " valid/ack"}, {30'd0, rdValid, pollAck}, {30'd0, 1'b1, eA});
    @(negedge clk);
    chk({tag, " valid drops"}, 32'(rdValid), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C3A_5E07));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkState("R1");
    chk("R1 pulses", {26'd0, initClr, eoiReq, eoiSpec, eoiRot, setPrio, rdValid},
        32'd0);
    doRead(1'b0, 8'hA5, 8'h3C, 1'b0, 3'd0);  // R1 read-select 0 -> request reg

    // R6 normal mask write, read back
    doWrite(1'b1, 8'h5A);
    doRead(1'b1, 8'h00, 8'h00, 1'b0, 3'd0);
    // R7 read-select then in-service read
    doWrite(1'b0, 8'h0B);
    doRead(1'b0, 8'h11, 8'h82, 1'b0, 3'd0);
    doWrite(1'b0, 8'h68);                    // R7 special mask on
    doWrite(1'b0, 8'h28);                    // R7 bit6 clear: no change
    // R2..R5 sequence with fourth word
    doWrite(1'b0, 8'h11);
    doWrite(1'b1, 8'hC7);                    // R3 base = 0x18
    doWrite(1'b1, 8'hFF);                    // R4 discarded
    doWrite(1'b1, 8'h12);                    // R5 nested + auto-EOI
    doWrite(1'b1, 8'h3C);                    // R6 mask again
    // R2..R4 sequence without fourth word clears modes
    doWrite(1'b0, 8'h10);
    doWrite(1'b1, 8'h40);
    doWrite(1'b1, 8'h99);
    doWrite(1'b1, 8'h77);                    // R4 now a mask load
    doRead(1'b1, 8'h00, 8'h00, 1'b0, 3'd0);
    // R8 / R9 all command codes
    for (int c = 0; c < 8; c++) doWrite(1'b0, {c[2:0], 5'b00101});
    doWrite(1'b0, 8'h80);                    // R8 rotate on
    doWrite(1'b0, 8'h00);                    // R8 rotate off
    // R11 poll hit and miss, then normal read again
    doWrite(1'b0, 8'h0C);
    doRead(1'b1, 8'h00, 8'h00, 1'b1, 3'd5);
    doWrite(1'b0, 8'h0C);
    doRead(1'b0, 8'h00, 8'h00, 1'b0, 3'd2);
    doRead(1'b0, 8'h6E, 8'h01, 1'b1, 3'd4);
    // restart mid-sequence (R2)
    doWrite(1'b0, 8'h11);
    doWrite(1'b1, 8'h08);
    doWrite(1'b0, 8'h10);
    doWrite(1'b1, 8'hF8);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [7:0] d;
      k = int'($urandom_range(0, 9));
      d = 8'($urandom);
      if (k < 3) doRead(1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 3'($urandom));
      else if (k < 5) doWrite(1'b1, d);
      else if (k == 5) doWrite(1'b0, {d[7:5], 1'b1, d[3:0]});
      else if (k < 8) doWrite(1'b0, {d[7:5], 2'b01, d[2:0]});
      else doWrite(1'b0, {d[7:5], 2'b00, d[2:0]});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule